// File: doc/BRIEF.md
# Retriggerable Audio Overload Detector

This block watches a stereo pair of signed sample streams that have already been through the optional DC-removal high-pass stage. Each sample arrives with a valid strobe, and the samples may be wider than 18 bits. Every accepted sample is saturated to the 18-bit two's-complement range, -131072 to +131071. The clipped value is presented at the outputs one clock after the strobe.

At the same time, the magnitude of each clipped channel is compared against a level about 1.023 dB below full scale. If either channel's magnitude is above that level, an overload flag goes high. The flag then stays high for a fixed number of system clock cycles. By default this is 131072 cycles, which is 512 sample periods when the clock runs at 256 times the sample rate. Every further violation restarts the full hold time. A standby input forces the flag low and discards any hold in progress.

Top module: `overload_hold_monitor`

## Requirements
- R1: An accepted sample above +131071 is presented at its channel output as +131071 one clock after the valid strobe.
- R2: An accepted sample below -131072 is presented at its channel output as -131072 one clock after the valid strobe.
- R3: An accepted sample within the 18-bit range appears unchanged at its channel output one clock after the strobe. While the strobe is low, the outputs keep their last values.
- R4: The flag goes high on the clock edge that accepts a sample whose clipped magnitude on either channel exceeds 116508 (parameter THRESH). A magnitude of exactly 116508 does not trigger, and the negative side uses the same magnitude test.
- R5: Once triggered, and with no further violation, the flag stays high for exactly HOLD clock cycles and then falls.
- R6: A violation while the flag is high restarts the full HOLD window from that edge.
- R7: While standby is high, the flag is low in the same cycle, the hold is cleared, and violating samples do not arm the flag. After standby falls, the flag stays low until a new violation arrives.
- R8: Sample values present while the valid strobe is low never trigger the flag.
- R9: After reset, both channel outputs are 0 and the flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 256 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | High forces the flag low and clears the hold |
| smp_valid | input | 1 | Strobe marking a new sample pair |
| left_in | input | IN_W | Left sample, signed, possibly wider than 18 bits |
| right_in | input | IN_W | Right sample, signed |
| left_out | output | OUT_W | Saturated left sample |
| right_out | output | OUT_W | Saturated right sample |
| ovl_flag | output | 1 | Overload indication, held high after each violation |

## Verification
The hardest case to reach from the ports is a second violation that lands in the middle of an active hold. The bench arms the flag and waits part of the window. It then injects another over-threshold sample and counts cycles until the flag falls, which shows that the window is measured from the second event rather than the first. The hold length is reduced to 40 cycles through the parameter so that the exact fall cycle can be checked. The threshold edge is reached by driving magnitudes of 116508 and 116509 directly, on both the positive and the negative side.

// File: rtl/overload_hold_monitor.sv
module overload_hold_monitor #(
  parameter int IN_W   = 20,
  parameter int OUT_W  = 18,
  parameter int THRESH = 116508,
  parameter int HOLD   = 131072
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    standby,
  input  logic                    smp_valid,
  input  logic signed [IN_W-1:0]  left_in,
  input  logic signed [IN_W-1:0]  right_in,
  output logic signed [OUT_W-1:0] left_out,
  output logic signed [OUT_W-1:0] right_out,
  output logic                    ovl_flag
);
  localparam int CNT_W = $clog2(HOLD + 1);
  localparam logic signed [IN_W-1:0]  MAX_IN  = {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0]  MIN_IN  = {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
  localparam logic signed [OUT_W-1:0] MAX_OUT = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] MIN_OUT = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W:0]          THR     = (OUT_W+1)'(THRESH);
  localparam logic [CNT_W-1:0]        LOAD    = CNT_W'(HOLD);

  function automatic logic signed [OUT_W-1:0] sat(input logic signed [IN_W-1:0] x);
    if (x > MAX_IN)      sat = MAX_OUT;
    else if (x < MIN_IN) sat = MIN_OUT;
    else                 sat = x[OUT_W-1:0];
  endfunction

  function automatic logic [OUT_W:0] mag(input logic signed [OUT_W-1:0] c);
    logic signed [OUT_W:0] e;
    e = {c[OUT_W-1], c};
    mag = e[OUT_W] ? $unsigned(-e) : $unsigned(e);
  endfunction

  logic signed [OUT_W-1:0] l_sat, r_sat;
  logic                    hit;
  logic [CNT_W-1:0]        cnt;

  assign l_sat = sat(left_in);
  assign r_sat = sat(right_in);
  assign hit   = smp_valid && !standby && ((mag(l_sat) > THR) || (mag(r_sat) > THR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_out  <= '0;
      right_out <= '0;
    end else if (smp_valid) begin
      left_out  <= l_sat;
      right_out <= r_sat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (standby)     cnt <= '0;
    else if (hit)         cnt <= LOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign ovl_flag = (cnt != '0) && !standby;

  // R1
  pos_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && (left_in > MAX_IN) |=> left_out == MAX_OUT);
  // R2
  neg_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && (right_in < MIN_IN) |=> right_out == MIN_OUT);
  // R3
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(left_out) && $stable(right_out));
  // R4
  arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit ##1 !standby |-> ovl_flag);
  // R5
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) && !hit && !standby |=> cnt == $past(cnt) - 1'b1);
  // R7
  standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> cnt == '0);
endmodule

// File: tb/test_overload_hold_monitor.sv
`timescale 1ns/1ps
module test_overload_hold_monitor;
  localparam int IN_W = 20;
  localparam int OUT_W = 18;
  localparam int HOLD = 40;

  logic clk = 1'b0, rst_n = 1'b0, standby = 1'b0, smp_valid = 1'b0;
  logic signed [IN_W-1:0]  left_in = '0, right_in = '0;
  logic signed [OUT_W-1:0] left_out, right_out;
  logic ovl_flag;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  overload_hold_monitor #(.IN_W(IN_W), .OUT_W(OUT_W), .THRESH(116508), .HOLD(HOLD)) i_overload_hold_monitor (
    .clk(clk), .rst_n(rst_n), .standby(standby), .smp_valid(smp_valid),
    .left_in(left_in), .right_in(right_in),
    .left_out(left_out), .right_out(right_out), .ovl_flag(ovl_flag));

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input int l, input int r);
    @(negedge clk);
    left_in = IN_W'(l); right_in = IN_W'(r); smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R9 left_out", left_out, 0);
    chk("R9 right_out", right_out, 0);
    chk("R9 flag", ovl_flag, 0);
  endtask

  task automatic t_clip;
    drive(200000, -200000);
    chk("R1 left clip", left_out, 131071);
    chk("R2 right clip", right_out, -131072);
    idle(HOLD + 2);
    drive(-300000, 131072);
    chk("R2 left clip", left_out, -131072);
    chk("R1 right clip", right_out, 131071);
    idle(HOLD + 2);
    drive(1234, -5678);
    chk("R3 left pass", left_out, 1234);
    chk("R3 right pass", right_out, -5678);
    chk("R4 small no flag", ovl_flag, 0);
  endtask

  task automatic t_valid_low;
    @(negedge clk);
    left_in = 20'sd250000; right_in = -20'sd250000; smp_valid = 1'b0;
    idle(4);
    chk("R8 flag with valid low", ovl_flag, 0);
    chk("R3 left held", left_out, 1234);
    chk("R3 right held", right_out, -5678);
  endtask

  task automatic t_threshold;
    drive(116508, -116508);
    chk("R4 at threshold", ovl_flag, 0);
    drive(116509, 0);
    chk("R4 left over", ovl_flag, 1);
    idle(HOLD + 2);
    drive(0, -116509);
    chk("R4 right negative over", ovl_flag, 1);
    idle(HOLD + 2);
    chk("R5 idle after hold", ovl_flag, 0);
  endtask

  task automatic t_hold;
    drive(120000, 0);
    chk("R5 armed", ovl_flag, 1);
    idle(HOLD - 1);
    chk("R5 last held cycle", ovl_flag, 1);
    idle(1);
    chk("R5 fall", ovl_flag, 0);
  endtask

  task automatic t_retrigger;
    drive(0, 125000);
    idle(20);
    chk("R6 mid hold", ovl_flag, 1);
    drive(0, -125000);
    idle(HOLD - 1);
    chk("R6 extended", ovl_flag, 1);
    idle(1);
    chk("R6 fall after restart", ovl_flag, 0);
  endtask

  task automatic t_standby;
    drive(130000, 0);
    chk("R7 armed", ovl_flag, 1);
    @(negedge clk);
    standby = 1'b1;
    #1;
    chk("R7 forced low", ovl_flag, 0);
    drive(-130000, 130000);
    chk("R7 ignored in standby", ovl_flag, 0);
    @(negedge clk);
    standby = 1'b0;
    idle(2);
    chk("R7 no resume", ovl_flag, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_clip();
    t_valid_low();
    t_threshold();
    t_hold();
    idle(2);
    t_retrigger();
    idle(2);
    t_standby();
    idle(2);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule